// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block produces the digital drive levels for an area image sensor that has a two-phase vertical shift structure (V1, V2) and a two-phase horizontal shift register (H1, H2). It also produces a separate drive for the last horizontal gate, H1L, and a one-clock sample strobe for the downstream converter. A start pulse begins a frame. The frame has three parts: an exposure window of programmable length, then, for every row, a vertical transfer that moves the row into the horizontal register, and a horizontal shift that moves that row out pixel by pixel.

The vertical transfer pulses V1 and then V2, with low dead time around each pulse. It ends when V2 falls, and H1 is held high across that edge. The horizontal shift toggles H1 and H2 in opposite halves of each pixel period. H1L drops one system clock before H1, and each H1L fall dumps one charge packet onto the output node. The sample strobe follows each of those falls after a fixed delay. The row length, the row count, the pulse widths and the strobe delay are elaboration parameters. The exposure length is an input that is captured when the frame starts.

Top module: `ccd_clk_seq`

## Requirements
- R1: After reset, and whenever no frame is running, the outputs rest at V1=0, V2=0, H1=1, H2=0, H1L=1 and sample=0.
- R2: A start_i pulse in idle captures int_time_i and begins exposure. The exposure lasts int_time_i+1 clocks, and V1 and V2 stay low throughout it. V1 first rises V_DEAD clocks after the exposure ends, which is int_time_i+2+V_DEAD clocks after the capturing edge. Changing int_time_i after capture has no effect on the frame.
- R3: V1 and V2 are never high together. Each row transfer is, in order: V_DEAD clocks with both low, V1 high for V_HIGH clocks, V_DEAD clocks with both low, V2 high for V_HIGH clocks, and V_DEAD clocks with both low.
- R4: Every falling edge of V2 happens while H1 is high on both sides of the edge and H2 is low.
- R5: H1 and H2 are never high together. During a horizontal shift each pixel period is H_HALF clocks with H1 high and H2 low, followed by H_HALF clocks with H1 low and H2 high.
- R6: H1L falls exactly one clock before every H1 fall. Each row produces exactly PIXELS H1L falls.
- R7: sample_o goes high for exactly one clock, STB_DLY clocks after every H1L fall, and only then.
- R8: After LINES rows the block returns to idle. The last horizontal half-period ends exactly LINES*(3*V_DEAD+2*V_HIGH+2*H_HALF*PIXELS)-V_DEAD clocks after the first V1 rise. A start_i pulse while a frame is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame; sampled only in idle |
| int_time_i | input | INT_W | Exposure length minus one, in clocks |
| v1_o | output | 1 | Vertical phase 1 drive |
| v2_o | output | 1 | Vertical phase 2 drive |
| h1_o | output | 1 | Horizontal phase 1 drive |
| h2_o | output | 1 | Horizontal phase 2 drive |
| h1l_o | output | 1 | Last horizontal gate drive; its fall dumps a packet |
| sample_o | output | 1 | One-clock strobe following each packet dump |

## Verification
The assertions take for granted that the parameters are legal: H_HALF is at least 2, STB_DLY is between 1 and H_HALF, and V_DEAD and V_HIGH are at least 1. Under those conditions the strobe always lands while H1L is still low, and the H1L fall always comes one clock ahead of the H1 fall. They assume nothing about start_i or int_time_i. The stimulus therefore pulses start_i at random points inside running frames and changes int_time_i right after capture. It also drops start_i a few clocks before each frame ends, so that the end-of-frame timing and the idle levels can be measured.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_INTEG  = 2'd1,
    ST_VXFER  = 2'd2,
    ST_HSHIFT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
  import ccd_seq_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int PIXELS  = 6,
  parameter int LINES   = 3,
  parameter int V_HIGH  = 3,
  parameter int V_DEAD  = 2,
  parameter int H_HALF  = 2,
  localparam int VX_CYC = 3 * V_DEAD + 2 * V_HIGH,
  localparam int HP_CYC = 2 * H_HALF,
  localparam int VS_W   = $clog2(VX_CYC + 1),
  localparam int HP_W   = $clog2(HP_CYC + 1),
  localparam int PX_W   = $clog2(PIXELS + 1),
  localparam int LN_W   = $clog2(LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_time_i,
  output seq_state_e       state_o,
  output logic [VS_W-1:0]  vstep_o,
  output logic [HP_W-1:0]  hphase_o
);
  localparam logic [VS_W-1:0] VS_LAST = VS_W'(VX_CYC - 1);
  localparam logic [HP_W-1:0] HP_LAST = HP_W'(HP_CYC - 1);
  localparam logic [PX_W-1:0] PX_LAST = PX_W'(PIXELS - 1);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(LINES - 1);

  seq_state_e       state_q, state_d;
  logic [INT_W-1:0] int_cnt_q, int_cnt_d;
  logic [VS_W-1:0]  vs_q, vs_d;
  logic [HP_W-1:0]  hp_q, hp_d;
  logic [PX_W-1:0]  px_q, px_d;
  logic [LN_W-1:0]  ln_q, ln_d;

  always_comb begin
    state_d   = state_q;
    int_cnt_d = int_cnt_q;
    vs_d      = vs_q;
    hp_d      = hp_q;
    px_d      = px_q;
    ln_d      = ln_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_INTEG;
          int_cnt_d = int_time_i;
          ln_d      = '0;
        end
      end
      ST_INTEG: begin
        if (int_cnt_q == '0) begin
          state_d = ST_VXFER;
          vs_d    = '0;
        end else begin
          int_cnt_d = int_cnt_q - 1'b1;
        end
      end
      ST_VXFER: begin
        if (vs_q == VS_LAST) begin
          state_d = ST_HSHIFT;
          hp_d    = '0;
          px_d    = '0;
        end else begin
          vs_d = vs_q + 1'b1;
        end
      end
      ST_HSHIFT: begin
        if (hp_q == HP_LAST) begin
          hp_d = '0;
          if (px_q == PX_LAST) begin
            if (ln_q == LN_LAST) begin
              state_d = ST_IDLE;
              ln_d    = '0;
            end else begin
              state_d = ST_VXFER;
              vs_d    = '0;
              ln_d    = ln_q + 1'b1;
            end
          end else begin
            px_d = px_q + 1'b1;
          end
        end else begin
          hp_d = hp_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      int_cnt_q <= '0;
      vs_q      <= '0;
      hp_q      <= '0;
      px_q      <= '0;
      ln_q      <= '0;
    end else begin
      state_q   <= state_d;
      int_cnt_q <= int_cnt_d;
      vs_q      <= vs_d;
      hp_q      <= hp_d;
      px_q      <= px_d;
      ln_q      <= ln_d;
    end
  end

  assign state_o  = state_q;
  assign vstep_o  = vs_q;
  assign hphase_o = hp_q;

  assert_vs_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_q <= VS_LAST);
  assert_line_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_q <= LN_LAST);
endmodule

// File: rtl/ccd_vclk_gen.sv
module ccd_vclk_gen
  import ccd_seq_pkg::*;
#(
  parameter int V_HIGH  = 3,
  parameter int V_DEAD  = 2,
  localparam int VX_CYC = 3 * V_DEAD + 2 * V_HIGH,
  localparam int VS_W   = $clog2(VX_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  seq_state_e      state_i,
  input  logic [VS_W-1:0] vstep_i,
  output logic            v1_o,
  output logic            v2_o
);
  localparam logic [VS_W-1:0] V1_ON  = VS_W'(V_DEAD);
  localparam logic [VS_W-1:0] V1_OFF = VS_W'(V_DEAD + V_HIGH);
  localparam logic [VS_W-1:0] V2_ON  = VS_W'(2 * V_DEAD + V_HIGH);
  localparam logic [VS_W-1:0] V2_OFF = VS_W'(2 * V_DEAD + 2 * V_HIGH);

  logic in_xfer, v1_d, v2_d;

  assign in_xfer = (state_i == ST_VXFER);
  assign v1_d    = in_xfer && (vstep_i >= V1_ON) && (vstep_i < V1_OFF);
  assign v2_d    = in_xfer && (vstep_i >= V2_ON) && (vstep_i < V2_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_o <= 1'b0;
      v2_o <= 1'b0;
    end else begin
      v1_o <= v1_d;
      v2_o <= v2_d;
    end
  end

  assert_v_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(v1_o && v2_o));
  assert_v1_lead_dead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(v2_o) |-> $past(!v1_o));
endmodule

// File: rtl/ccd_hclk_gen.sv
module ccd_hclk_gen
  import ccd_seq_pkg::*;
#(
  parameter int H_HALF  = 2,
  localparam int HP_CYC = 2 * H_HALF,
  localparam int HP_W   = $clog2(HP_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  seq_state_e      state_i,
  input  logic [HP_W-1:0] hphase_i,
  output logic            h1_o,
  output logic            h2_o,
  output logic            h1l_o
);
  localparam logic [HP_W-1:0] H1_END  = HP_W'(H_HALF);
  localparam logic [HP_W-1:0] H1L_END = HP_W'(H_HALF - 1);

  logic shifting, h1_d, h2_d, h1l_d;

  // outside a shift H1 parks high so V2 can fall onto it
  assign shifting = (state_i == ST_HSHIFT);
  assign h1_d     = !shifting || (hphase_i < H1_END);
  assign h2_d     = shifting && (hphase_i >= H1_END);
  assign h1l_d    = !shifting || (hphase_i < H1L_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_o  <= 1'b1;
      h2_o  <= 1'b0;
      h1l_o <= 1'b1;
    end else begin
      h1_o  <= h1_d;
      h2_o  <= h2_d;
      h1l_o <= h1l_d;
    end
  end

  assert_h_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(h1_o && h2_o));
  assert_h1l_leads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(h1l_o) |=> $fell(h1_o));
  assert_h1_fall_after_h1l_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(h1_o) |-> $past(!h1l_o));
endmodule

// File: rtl/ccd_strobe_gen.sv
module ccd_strobe_gen #(
  parameter int STB_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic h1l_i,
  output logic sample_o
);
  logic h1l_q, dump;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) h1l_q <= 1'b1;
    else         h1l_q <= h1l_i;
  end

  assign dump = h1l_q && !h1l_i;

  logic [STB_DLY-1:0] pipe_q;

  generate
    if (STB_DLY == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= dump;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STB_DLY-2:0], dump};
      end
    end
  endgenerate

  assign sample_o = pipe_q[STB_DLY-1];

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  assert_strobe_in_dump_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !h1l_i);
endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
  import ccd_seq_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int PIXELS  = 6,
  parameter int LINES   = 3,
  parameter int V_HIGH  = 3,
  parameter int V_DEAD  = 2,
  parameter int H_HALF  = 2,
  parameter int STB_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_time_i,
  output logic             v1_o,
  output logic             v2_o,
  output logic             h1_o,
  output logic             h2_o,
  output logic             h1l_o,
  output logic             sample_o
);
  localparam int VX_CYC = 3 * V_DEAD + 2 * V_HIGH;
  localparam int HP_CYC = 2 * H_HALF;
  localparam int VS_W   = $clog2(VX_CYC + 1);
  localparam int HP_W   = $clog2(HP_CYC + 1);

  seq_state_e      state;
  logic [VS_W-1:0] vstep;
  logic [HP_W-1:0] hphase;

  ccd_seq_fsm #(
    .INT_W (INT_W),
    .PIXELS(PIXELS),
    .LINES (LINES),
    .V_HIGH(V_HIGH),
    .V_DEAD(V_DEAD),
    .H_HALF(H_HALF)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .int_time_i(int_time_i),
    .state_o   (state),
    .vstep_o   (vstep),
    .hphase_o  (hphase)
  );

  ccd_vclk_gen #(
    .V_HIGH(V_HIGH),
    .V_DEAD(V_DEAD)
  ) u_vclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .vstep_i(vstep),
    .v1_o   (v1_o),
    .v2_o   (v2_o)
  );

  ccd_hclk_gen #(
    .H_HALF(H_HALF)
  ) u_hclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .hphase_i(hphase),
    .h1_o    (h1_o),
    .h2_o    (h2_o),
    .h1l_o   (h1l_o)
  );

  ccd_strobe_gen #(
    .STB_DLY(STB_DLY)
  ) u_stb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .h1l_i   (h1l_o),
    .sample_o(sample_o)
  );

  assert_integ_dark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state == ST_INTEG) |-> (!v1_o && !v2_o));
  assert_v2_fall_on_h1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(v2_o) |-> (h1_o && !h2_o && $past(h1_o)));
  assert_idle_levels_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state == ST_IDLE) |-> (!v1_o && !v2_o && h1_o && !h2_o && h1l_o));
endmodule

// File: tb/ccd_clk_seq_tb_top.sv
module ccd_clk_seq_tb_top;
  localparam int INT_W   = 16;
  localparam int PIXELS  = 6;
  localparam int LINES   = 3;
  localparam int V_HIGH  = 3;
  localparam int V_DEAD  = 2;
  localparam int H_HALF  = 2;
  localparam int STB_DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [INT_W-1:0] int_time = '0;
  logic v1, v2, h1, h2, h1l, smp;

  always #5 clk = ~clk;

  ccd_clk_seq #(
    .INT_W(INT_W), .PIXELS(PIXELS), .LINES(LINES), .V_HIGH(V_HIGH),
    .V_DEAD(V_DEAD), .H_HALF(H_HALF), .STB_DLY(STB_DLY)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .int_time_i(int_time),
    .v1_o(v1), .v2_o(v2), .h1_o(h1), .h2_o(h2), .h1l_o(h1l), .sample_o(smp)
  );

  int n_run = 0;
  int n_fail = 0;

  function automatic int line_cyc();
    return 3 * V_DEAD + 2 * V_HIGH + 2 * H_HALF * PIXELS;
  endfunction
  function automatic int exp_v1_idx(int it);
    return it + 2 + V_DEAD;
  endfunction
  function automatic int exp_tail();
    return LINES * line_cyc() - V_DEAD;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // output monitor
  bit mon_en = 0;
  int cyc = 0;
  logic pv1, pv2, ph1, ph2, ph1l, psmp;
  int v1_rise = 0, v1_fall = 0, h2_rise = 0, last_fall = -100;
  int line_falls = 0, falls = 0, strb = 0, v2f = 0;
  bit line_valid = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      chk(!(v1 && v2), "R3 V overlap", int'(v1 && v2), 0);
      chk(!(h1 && h2), "R5 H overlap", int'(h1 && h2), 0);
      if (v1 && !pv1) v1_rise = cyc;
      if (!v1 && pv1) begin
        v1_fall = cyc;
        chk(cyc - v1_rise == V_HIGH, "R3 V1 width", cyc - v1_rise, V_HIGH);
      end
      if (v2 && !pv2)
        chk(cyc - v1_fall == V_DEAD, "R3 dead gap", cyc - v1_fall, V_DEAD);
      if (!v2 && pv2) begin
        chk(h1 && ph1 && !h2, "R4 H1 at V2 fall", int'(h1 && ph1 && !h2), 1);
        if (line_valid)
          chk(line_falls == PIXELS, "R6 dumps per line", line_falls, PIXELS);
        line_falls = 0;
        line_valid = 1;
        v2f++;
      end
      if (!h1l && ph1l) begin
        line_falls++;
        falls++;
        last_fall = cyc;
      end
      if (!h1 && ph1)
        chk(cyc - last_fall == 1, "R6 H1L lead", cyc - last_fall, 1);
      if (h2 && !ph2) h2_rise = cyc;
      if (!h2 && ph2)
        chk(cyc - h2_rise == H_HALF, "R5 H2 width", cyc - h2_rise, H_HALF);
      if (smp) begin
        chk(!psmp, "R7 strobe width", int'(psmp), 0);
        chk(cyc - last_fall == STB_DLY, "R7 strobe delay", cyc - last_fall, STB_DLY);
        strb++;
      end
    end
    pv1 = v1; pv2 = v2; ph1 = h1; ph2 = h2; ph1l = h1l; psmp = smp;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check_idle(string req);
    chk(!v1 && !v2 && h1 && !h2 && h1l && !smp, req,
        {26'd0, v1, v2, h1, h2, h1l, smp}, 6'b001010);
  endtask

  task automatic run_frame(int it, bit noise);
    int n;
    int f0, s0, v0, tail;
    f0 = falls; s0 = strb; v0 = v2f;
    start = 1'b1;
    int_time = INT_W'(it);
    step();
    start = 1'b0;
    if (noise) int_time = INT_W'($urandom_range(0, 200));
    n = 0;
    while (!v1 && n < 1000) begin
      if (v2) chk(0, "R2 V2 during exposure", 1, 0);
      if (noise) start = ($urandom_range(0, 7) == 0);
      step();
      n++;
    end
    chk(n == exp_v1_idx(it), "R2 exposure length", n, exp_v1_idx(it));
    tail = exp_tail();
    for (int k = 1; k <= tail; k++) begin
      start = noise && (k < tail - 3) && ($urandom_range(0, 7) == 0);
      step();
      if (k == tail - 1) chk(h2 == 1'b1, "R8 last half-period", int'(h2), 1);
    end
    start = 1'b0;
    check_idle("R8 idle at frame end");
    chk(falls - f0 == PIXELS * LINES, "R6 dumps per frame", falls - f0, PIXELS * LINES);
    chk(strb - s0 == PIXELS * LINES, "R7 strobes per frame", strb - s0, PIXELS * LINES);
    chk(v2f - v0 == LINES, "R8 line count", v2f - v0, LINES);
    chk(line_falls == PIXELS, "R6 last line dumps", line_falls, PIXELS);
    f0 = falls;
    repeat (line_cyc()) step();
    chk(falls == f0, "R8 stays idle", falls - f0, 0);
    check_idle("R1 idle levels");
  endtask

  initial begin
    #(500_000 * 1ns);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED_0C0D;
    void'($urandom(seed));
    repeat (3) step();
    check_idle("R1 reset levels");
    rst_n = 1'b1;
    repeat (3) step();
    check_idle("R1 idle after reset");
    mon_en = 1;
    run_frame(0, 0);
    run_frame(1, 0);
    run_frame(30, 1);
    for (int i = 0; i < 8; i++) run_frame($urandom_range(0, 15), 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule